// File: doc/BRIEF.md
# Reloadable Up/Down Event Counter

This block counts qualified edges of an external event input with a 16-bit counter that reloads from a programmable value. In the down direction it produces one terminal event every n+1 qualified edges, where n is the reload value. In the up direction it produces one every 0xFFFF−n+1 edges. Each terminal event gives a one-cycle pulse on `term_o`. When the pulse-output option is selected, each terminal event also toggles the output pin.

A host programs the block through three write strobes that share one data bus:
- a 16-bit count/reload write;
- an 8-bit mode write;
- a one-bit direction register write.

The host reads back the live count and the mode. The mode selects the counting edge and the direction source, which is either the internal register bit or an external direction pin. The event input and the direction pin are both brought into the clock domain through a flip-flop synchronizer.

Top module: `evc_top`

## Requirements
- R1: After reset, `cnt_rd` is 0, `mode_rd` is 0, and `term_o`, `pout_o` and `pout_oe_o` are all 0.
- R2: Counting down (decrement from n; on a qualified edge at 0, reload n), a terminal pulse occurs once every n+1 qualified edges.
- R3: Counting up (increment from n; on a qualified edge at 0xFFFF, reload n), a terminal pulse occurs once every 0xFFFF−n+1 qualified edges.
- R4: `cnt_rd` always returns the live counter value, not the stored reload value.
- R5: The counter changes on qualified edges only while `run_i` is 1 and mode bits [1:0] equal 2'b01. Otherwise, edges leave the count unchanged.
- R6: Mode bit 3 selects the counted edge of `evt_i`: 1 selects rising, 0 selects falling. The other edge is not counted.
- R7: Mode bit 4 selects the direction source, and for both sources 1 means up and 0 means down.
  - When bit 4 is 0, the source is the register bit written by `updn_we` from `wdata[0]`.
  - When bit 4 is 1, the source is the synchronized level of `dir_i`.
- R8: The effect of a `cnt_we` write depends on whether the counter is active (as defined in R5).
  - While the counter is not active, the write loads both the counter and the reload value.
  - While it is active, the write changes only the reload value, and the new value is used from the next reload on.
- R9: `term_o` is high for exactly one cycle per terminal event.
  - When mode bit 2 is 1, `pout_o` toggles one cycle after each terminal pulse.
  - `pout_oe_o` follows mode bit 2.
- R10: Mode bits [7:5] have no effect on counting and read back as 0.
- R11: A change on `evt_i` is counted at the third rising clock edge after it is applied, and the count moves by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Count enable (start/stop) |
| cnt_we | input | 1 | Count/reload register write strobe |
| mode_we | input | 1 | Mode register write strobe (uses wdata[7:0]) |
| updn_we | input | 1 | Direction register write strobe (uses wdata[0]) |
| wdata | input | 16 | Host write data |
| cnt_rd | output | 16 | Live counter value |
| mode_rd | output | 8 | Mode readback, bits [7:5] read 0 |
| evt_i | input | 1 | External event input (asynchronous) |
| dir_i | input | 1 | External direction input (asynchronous), 1 = up |
| term_o | output | 1 | One-cycle underflow/overflow pulse |
| pout_o | output | 1 | Toggling pulse output |
| pout_oe_o | output | 1 | Output enable for the pulse pin |

## Verification
The assertions assume that `evt_i` changes no faster than once every two clocks. This means no two qualified edges fall in adjacent cycles, so terminal pulses cannot be back to back. They also assume that `cnt_we` is the only path other than counting that moves the count. The stimulus meets the first assumption by holding every event level for three clock cycles. It changes `dir_i` and the mode only while the counter is stopped, and waits for the synchronizer to settle before it sets `run_i`.

// File: rtl/evc_pkg.sv
package evc_pkg;
   localparam logic [1:0] OP_EVENT = 2'b01;

   typedef struct packed {
      logic       dir_pin;
      logic       rise_edge;
      logic       pulse_en;
      logic [1:0] op;
   } evc_mode_t;
endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("evc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/evc_edge.sv
module evc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic hit
);
   logic prev;

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign hit = rise_sel ? (lvl & ~prev) : (~lvl & prev);
endmodule

// File: rtl/evc_core.sv
module evc_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         hit,
   input  logic         up,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt,
   output logic         term
);
   localparam logic [W-1:0] TOP = '1;
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] reload_q;
   logic [W-1:0] cnt_q;
   logic         term_q;
   logic         at_limit;

   assign at_limit = up ? (cnt_q == TOP) : (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
         term_q   <= 1'b0;
      end else begin
         term_q <= 1'b0;
         if (wr) reload_q <= wdata;
         if (wr && !active) begin
            cnt_q <= wdata;
         end else if (active && hit) begin
            if (at_limit) begin
               cnt_q  <= reload_q;
               term_q <= 1'b1;
            end else if (up) begin
               cnt_q <= cnt_q + ONE;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   assign cnt  = cnt_q;
   assign term = term_q;
endmodule

// File: rtl/evc_pout.sv
module evc_pout (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic term,
   output logic pout
);
   logic pout_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          pout_q <= 1'b0;
      else if (en && term) pout_q <= ~pout_q;
   end

   assign pout = pout_q;
endmodule

// File: rtl/evc_top.sv
module evc_top #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         cnt_we,
   input  logic         mode_we,
   input  logic         updn_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] cnt_rd,
   output logic [7:0]   mode_rd,
   input  logic         evt_i,
   input  logic         dir_i,
   output logic         term_o,
   output logic         pout_o,
   output logic         pout_oe_o
);
   import evc_pkg::*;

   localparam int MODE_BITS = $bits(evc_mode_t);

   if (W < 8) begin : g_bad_width
      $error("evc_top: W must be at least 8");
   end

   evc_mode_t mode_q;
   logic      updn_q;
   logic      evt_s, dir_s, hit, up, active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         updn_q <= 1'b0;
      end else begin
         if (mode_we) mode_q <= evc_mode_t'(wdata[MODE_BITS-1:0]);
         if (updn_we) updn_q <= wdata[0];
      end
   end

   assign active  = run_i && (mode_q.op == OP_EVENT);
   assign up      = mode_q.dir_pin ? dir_s : updn_q;
   assign mode_rd = {{(8-MODE_BITS){1'b0}}, mode_q};

   evc_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk(clk), .rst_n(rst_n), .d(evt_i), .q(evt_s)
   );

   evc_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
      .clk(clk), .rst_n(rst_n), .d(dir_i), .q(dir_s)
   );

   evc_edge u_edge (
      .clk(clk), .rst_n(rst_n), .lvl(evt_s),
      .rise_sel(mode_q.rise_edge), .hit(hit)
   );

   evc_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .active(active), .hit(hit), .up(up),
      .wr(cnt_we), .wdata(wdata), .cnt(cnt_rd), .term(term_o)
   );

   evc_pout u_pout (
      .clk(clk), .rst_n(rst_n), .en(mode_q.pulse_en),
      .term(term_o), .pout(pout_o)
   );

   assign pout_oe_o = mode_q.pulse_en;
endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run_i,
   input logic         cnt_we,
   input logic [1:0]   op_rd,
   input logic [W-1:0] cnt_rd,
   input logic         term_o,
   input logic         pout_o,
   input logic         pout_oe_o
);
   localparam logic [W-1:0] TOP = '1;

   assert_term_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |=> !term_o);

   assert_pout_on_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pout_o != $past(pout_o)) |-> ($past(term_o) && $past(pout_oe_o)));

   assert_frozen_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run_i || op_rd != 2'b01) && !cnt_we) |=> $stable(cnt_rd));

   assert_term_from_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |-> ($past(cnt_rd) == '0 || $past(cnt_rd) == TOP));

   assert_step_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_o && !$past(cnt_we)) |->
         (cnt_rd == $past(cnt_rd) ||
          cnt_rd == W'($past(cnt_rd) + W'(1)) ||
          cnt_rd == W'($past(cnt_rd) - W'(1))));
endmodule

bind evc_top evc_checker #(.W(W)) u_evc_chk (
   .clk(clk), .rst_n(rst_n), .run_i(run_i), .cnt_we(cnt_we),
   .op_rd(mode_rd[1:0]), .cnt_rd(cnt_rd), .term_o(term_o),
   .pout_o(pout_o), .pout_oe_o(pout_oe_o)
);

// File: tb/tb_evc_top.sv
module tb_evc_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0;
   logic        cnt_we = 1'b0, mode_we = 1'b0, updn_we = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] cnt_rd;
   logic [7:0]  mode_rd;
   logic        evt_i = 1'b0, dir_i = 1'b0;
   logic        term_o, pout_o, pout_oe_o;

   int checks = 0;
   int errors = 0;
   int term_seen = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   evc_top dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .cnt_we(cnt_we),
      .mode_we(mode_we), .updn_we(updn_we), .wdata(wdata),
      .cnt_rd(cnt_rd), .mode_rd(mode_rd), .evt_i(evt_i), .dir_i(dir_i),
      .term_o(term_o), .pout_o(pout_o), .pout_oe_o(pout_oe_o)
   );

   always @(negedge clk) if (rst_n && term_o) term_seen++;

   typedef struct packed {
      logic [7:0]  mode;
      logic        updn;
      logic        dir;
      logic [15:0] load;
      logic [7:0]  pairs;
      logic [15:0] exp_cnt;
      logic [7:0]  exp_terms;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'h09, 1'b0, 1'b0, 16'd5,    8'd3, 16'd2,    8'd0}, // R2 down, R4 live
      '{8'h09, 1'b0, 1'b0, 16'd5,    8'd6, 16'd5,    8'd1}, // R2 period n+1
      '{8'h09, 1'b0, 1'b0, 16'd0,    8'd4, 16'd0,    8'd4}, // R2 n=0
      '{8'h09, 1'b1, 1'b0, 16'hFFFC, 8'd3, 16'hFFFF, 8'd0}, // R3 up
      '{8'h09, 1'b1, 1'b0, 16'hFFFC, 8'd4, 16'hFFFC, 8'd1}, // R3 period
      '{8'h09, 1'b1, 1'b0, 16'hFFFF, 8'd3, 16'hFFFF, 8'd3}, // R3 n=FFFF
      '{8'h01, 1'b0, 1'b0, 16'd3,    8'd2, 16'd1,    8'd0}, // R6 falling
      '{8'hE9, 1'b0, 1'b0, 16'd2,    8'd3, 16'd2,    8'd1}, // R10 high bits
      '{8'h08, 1'b0, 1'b0, 16'd7,    8'd3, 16'd7,    8'd0}, // R5 op 00
      '{8'h1B, 1'b0, 1'b1, 16'd9,    8'd2, 16'd9,    8'd0}, // R5 op 11
      '{8'h19, 1'b1, 1'b0, 16'd10,   8'd2, 16'd8,    8'd0}  // R7 pin down
   };

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(input int sel, input logic [15:0] d);
      @(negedge clk);
      wdata = d;
      cnt_we  = (sel == 0);
      mode_we = (sel == 1);
      updn_we = (sel == 2);
      @(negedge clk);
      cnt_we = 1'b0; mode_we = 1'b0; updn_we = 1'b0;
   endtask

   task automatic pairs(input int n);
      for (int i = 0; i < n; i++) begin
         evt_i = 1'b1;
         repeat (3) @(negedge clk);
         evt_i = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic setup(input logic [7:0] m, input logic ud, input logic dr, input logic [15:0] n);
      run_i = 1'b0;
      dir_i = dr;
      host_wr(1, {8'h00, m});
      host_wr(2, {15'd0, ud});
      host_wr(0, n);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int base;
      logic p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 cnt",  cnt_rd, 0);
      check("R1 mode", mode_rd, 0);
      check("R1 term/pout/oe", {term_o, pout_o, pout_oe_o}, 0);

      // Vector table: R2 R3 R4 R5 R6 R7 R10
      for (int v = 0; v < NV; v++) begin
         setup(VECS[v].mode, VECS[v].updn, VECS[v].dir, VECS[v].load);
         base = term_seen;
         run_i = 1'b1;
         pairs(int'(VECS[v].pairs));
         repeat (2) @(negedge clk);
         check($sformatf("R2/R3/R4 vec%0d count", v), cnt_rd, VECS[v].exp_cnt);
         check($sformatf("R9 vec%0d terms", v), term_seen - base, VECS[v].exp_terms);
         run_i = 1'b0;
      end

      // R10 readback of high mode bits
      host_wr(1, 16'h00E9);
      check("R10 mode readback", mode_rd, 8'h09);

      // R5 stopped with event op: no counting
      setup(8'h09, 1'b0, 1'b0, 16'd6);
      pairs(3);
      check("R5 stopped count", cnt_rd, 16'd6);

      // R8 write while running goes to reload only
      run_i = 1'b1;
      pairs(2);
      check("R8 before write", cnt_rd, 16'd4);
      host_wr(0, 16'd11);
      check("R8 running write keeps count", cnt_rd, 16'd4);
      base = term_seen;
      pairs(5);
      check("R8 new reload used", cnt_rd, 16'd11);
      check("R8 one terminal", term_seen - base, 1);
      run_i = 1'b0;

      // R9 pulse output toggling
      setup(8'h0D, 1'b0, 1'b0, 16'd1);
      check("R9 oe", pout_oe_o, 1'b1);
      p0 = pout_o;
      check("R9 pout reset low", p0, 1'b0);
      run_i = 1'b1;
      pairs(2);
      repeat (2) @(negedge clk);
      check("R9 pout toggled", pout_o, 1'b1);
      pairs(2);
      repeat (2) @(negedge clk);
      check("R9 pout toggled back", pout_o, 1'b0);
      run_i = 1'b0;

      // R9 no toggle with pulse output off
      setup(8'h09, 1'b0, 1'b0, 16'd0);
      run_i = 1'b1;
      pairs(1);
      repeat (2) @(negedge clk);
      check("R9 pout held when disabled", {pout_o, pout_oe_o}, 2'b00);
      run_i = 1'b0;

      // R11 latency and R6 opposite edge ignored
      setup(8'h09, 1'b1, 1'b0, 16'd0);
      run_i = 1'b1;
      @(negedge clk);
      evt_i = 1'b1;
      @(negedge clk);
      check("R11 after edge 1", cnt_rd, 16'd0);
      @(negedge clk);
      check("R11 after edge 2", cnt_rd, 16'd0);
      @(negedge clk);
      check("R11 after edge 3", cnt_rd, 16'd1);
      evt_i = 1'b0;
      repeat (4) @(negedge clk);
      check("R6 falling ignored in rising mode", cnt_rd, 16'd1);
      run_i = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule